// File: doc/BRIEF.md
# Bus Slave Retry, Error and Parity Control

This block decides how a processor-bus slave port answers each transaction. In the single address-phase cycle it looks at the transaction type and at a set of status inputs. From these it decides whether to ask the master to retry. The same cycle decides whether the transfer is an unsupported misaligned one. The block also checks byte-lane parity on the received address and data, and it generates byte-lane parity for the address and data that the port drives back out.

A 16-bit control register sets its behaviour. Six low bits are read/write controls. Three sticky error flags are cleared by writing 1. The reset value is 0x0006. Control bits: [0] retry enable, [1] transfer-error enable, [2] misaligned acceptance, [3] address parity check, [4] data parity check, [5] parity polarity (0 odd, 1 even). Flags: [8] address parity error, [9] data parity error, [10] misaligned reject routed to interrupt. Every other bit reads 0.

An error is reported as a one-cycle transfer-error pulse, or through the interrupt alone when transfer errors are disabled. All registered outputs change on the clock edge that samples their inputs.

Top module: `bus_resp_ctrl`

## Requirements
- R1: With bit 0 set, `retry_out` is high for the single cycle after an address phase (`addr_valid`) in which at least one of these holds: a register write while `peer_reg_wr`; a register read while `eeprom_loading`; a posted write while `wbuf_free` is low; a read with `tgt_pci_a` or `tgt_pci_b`. In any other case it is low.
- R2: With bit 0 clear, `retry_out` is never asserted.
- R3: With bit 1 set, `terr_out` pulses for one cycle after any error event: a rejected misaligned transfer, or an enabled parity mismatch. With bit 1 clear, `terr_out` stays low.
- R4: With bit 2 clear, an address phase with `addr_misaligned` is rejected. It sets flag bit 10 only when bit 1 is clear. With bit 2 set, such a transfer raises no error.
- R5: With bit 3 set, a mismatch on any of the 4 address byte lanes during an address phase sets flag bit 8. With bit 3 clear, no mismatch sets it.
- R6: With bit 4 set, a mismatch on any of the 8 data byte lanes while `data_valid` sets flag bit 9. With bit 4 clear, no mismatch sets it.
- R7: A lane's parity bit makes the count of ones in the byte plus the parity bit odd when bit 5 is 0, and even when bit 5 is 1. Checks and generated parity both follow bit 5.
- R8: `addr_par_out` and `data_par_out` give the parity of `mst_addr` and `mst_data` one cycle later, whatever the check enables say.
- R9: Writing 1 to a flag bit clears it. A new error set in the same cycle wins over the clear. `irq_out` is high exactly while any flag is set.
- R10: Reset gives 0x0006. Bits 5:0 read back exactly what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| addr_valid | input | 1 | Address phase strobe |
| addr_is_read | input | 1 | Transaction is a read |
| addr_is_reg | input | 1 | Transaction targets the internal registers |
| addr_posted | input | 1 | Transaction is a posted write |
| addr_misaligned | input | 1 | Transfer is of the extended misaligned kind |
| tgt_pci_a | input | 1 | Read targets the first PCI-side port |
| tgt_pci_b | input | 1 | Read targets the second PCI-side port |
| peer_reg_wr | input | 1 | A master on another interface is writing registers |
| eeprom_loading | input | 1 | Serial configuration load in progress |
| wbuf_free | input | 1 | At least one posted-write buffer is free |
| bus_addr | input | 32 | Received address |
| bus_addr_par | input | 4 | Received address lane parity |
| data_valid | input | 1 | Received data beat strobe |
| bus_data | input | 64 | Received data |
| bus_data_par | input | 8 | Received data lane parity |
| mst_addr | input | 32 | Address the port drives |
| mst_data | input | 64 | Data the port drives |
| retry_out | output | 1 | Address retry request |
| terr_out | output | 1 | Transfer error |
| irq_out | output | 1 | Error interrupt |
| addr_par_out | output | 4 | Generated address lane parity |
| data_par_out | output | 8 | Generated data lane parity |

## Verification
The hardest case to reach is a flag clear that meets a new error in the same cycle, while the polarity bit is changed by that same write. The old polarity then decides the check, and the set must win over the clear. The random part writes the register often, with random flag-clear bits, during address and data phases that carry deliberately corrupted parity. Directed steps first walk each retry condition on its own, then each routing of a misaligned reject.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int CFG_W   = 16;
  localparam int CTL_W   = 6;
  localparam int FLG_W   = 3;
  localparam int FLG_LSB = 8;
  localparam int B_RETRY = 0;
  localparam int B_TERR  = 1;
  localparam int B_MISAL = 2;
  localparam int B_APCHK = 3;
  localparam int B_DPCHK = 4;
  localparam int B_EVEN  = 5;
  localparam logic [CTL_W-1:0] CTL_RST = 6'b000110;

  typedef struct packed {
    logic merr;
    logic dperr;
    logic aperr;
  } err_evt_t;
endpackage

// File: rtl/brc_lane_parity.sv
module brc_lane_parity #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    even,
  output logic [LANES-1:0]        par
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = (^din[g*LANE_W +: LANE_W]) ^ ~even;
  end
endmodule

// File: rtl/brc_retry.sv
module brc_retry (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic phase,
  input  logic is_read,
  input  logic is_reg,
  input  logic posted,
  input  logic peer_busy,
  input  logic ee_load,
  input  logic buf_free,
  input  logic pci_a,
  input  logic pci_b,
  output logic retry
);
  logic [3:0] cause;

  always_comb begin
    cause[0] = is_reg & ~is_read & peer_busy;
    cause[1] = is_reg & is_read & ee_load;
    cause[2] = posted & ~buf_free;
    cause[3] = is_read & (pci_a | pci_b);
  end

  always_ff @(posedge clk) begin
    if (rst) retry <= 1'b0;
    else     retry <= phase & en & (|cause);
  end
endmodule

// File: rtl/brc_cfg_regs.sv
module brc_cfg_regs
  import brc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  err_evt_t         evt,
  output logic [CTL_W-1:0] ctl,
  output logic [FLG_W-1:0] flags
);
  logic [FLG_W-1:0] clr;

  assign clr = we ? wdata[FLG_LSB +: FLG_W] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= CTL_RST;
      flags <= '0;
    end else begin
      if (we) ctl <= wdata[CTL_W-1:0];
      flags <= (flags & ~clr) | {evt.merr, evt.dperr, evt.aperr};
    end
  end
endmodule

// File: rtl/bus_resp_ctrl.sv
module bus_resp_ctrl
  import brc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [15:0]                cfg_wdata,
  output logic [15:0]                cfg_rdata,
  input  logic                       addr_valid,
  input  logic                       addr_is_read,
  input  logic                       addr_is_reg,
  input  logic                       addr_posted,
  input  logic                       addr_misaligned,
  input  logic                       tgt_pci_a,
  input  logic                       tgt_pci_b,
  input  logic                       peer_reg_wr,
  input  logic                       eeprom_loading,
  input  logic                       wbuf_free,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [ADDR_W/LANE_W-1:0]   bus_addr_par,
  input  logic                       data_valid,
  input  logic [DATA_W-1:0]          bus_data,
  input  logic [DATA_W/LANE_W-1:0]   bus_data_par,
  input  logic [ADDR_W-1:0]          mst_addr,
  input  logic [DATA_W-1:0]          mst_data,
  output logic                       retry_out,
  output logic                       terr_out,
  output logic                       irq_out,
  output logic [ADDR_W/LANE_W-1:0]   addr_par_out,
  output logic [DATA_W/LANE_W-1:0]   data_par_out
);
  localparam int AL = ADDR_W / LANE_W;
  localparam int DL = DATA_W / LANE_W;

  logic [CTL_W-1:0] ctl;
  logic [FLG_W-1:0] flags;
  logic [AL-1:0]    a_exp, a_gen;
  logic [DL-1:0]    d_exp, d_gen;
  logic             mis_rej, ap_bad, dp_bad;
  err_evt_t         evt;

  brc_lane_parity #(.LANES(AL), .LANE_W(LANE_W)) u_achk (
    .din(bus_addr), .even(ctl[B_EVEN]), .par(a_exp));
  brc_lane_parity #(.LANES(DL), .LANE_W(LANE_W)) u_dchk (
    .din(bus_data), .even(ctl[B_EVEN]), .par(d_exp));
  brc_lane_parity #(.LANES(AL), .LANE_W(LANE_W)) u_agen (
    .din(mst_addr), .even(ctl[B_EVEN]), .par(a_gen));
  brc_lane_parity #(.LANES(DL), .LANE_W(LANE_W)) u_dgen (
    .din(mst_data), .even(ctl[B_EVEN]), .par(d_gen));

  always_comb begin
    mis_rej   = addr_valid & addr_misaligned & ~ctl[B_MISAL];
    ap_bad    = addr_valid & ctl[B_APCHK] & (|(a_exp ^ bus_addr_par));
    dp_bad    = data_valid & ctl[B_DPCHK] & (|(d_exp ^ bus_data_par));
    evt.aperr = ap_bad;
    evt.dperr = dp_bad;
    evt.merr  = mis_rej & ~ctl[B_TERR];
  end

  brc_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .evt(evt), .ctl(ctl), .flags(flags));

  brc_retry u_retry (
    .clk(clk), .rst(rst), .en(ctl[B_RETRY]), .phase(addr_valid),
    .is_read(addr_is_read), .is_reg(addr_is_reg), .posted(addr_posted),
    .peer_busy(peer_reg_wr), .ee_load(eeprom_loading), .buf_free(wbuf_free),
    .pci_a(tgt_pci_a), .pci_b(tgt_pci_b), .retry(retry_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      terr_out     <= 1'b0;
      addr_par_out <= '0;
      data_par_out <= '0;
    end else begin
      terr_out     <= ctl[B_TERR] & (mis_rej | ap_bad | dp_bad);
      addr_par_out <= a_gen;
      data_par_out <= d_gen;
    end
  end

  assign cfg_rdata = {{(CFG_W-FLG_LSB-FLG_W){1'b0}}, flags,
                      {(FLG_LSB-CTL_W){1'b0}}, ctl};
  assign irq_out   = |flags;
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
  input logic        clk,
  input logic        rst,
  input logic        addr_valid,
  input logic [15:0] cfg_rdata,
  input logic        retry_out,
  input logic        terr_out
);
  AST_RETRY_AT_PHASE: assert property (@(posedge clk) disable iff (rst)
    retry_out |-> $past(addr_valid)); // R1
  AST_RETRY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    retry_out |-> $past(cfg_rdata[0])); // R2
  AST_TERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    terr_out |-> $past(cfg_rdata[1])); // R3
  AST_MERR_ROUTE: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rdata[10]) |-> ($past(addr_valid) && !$past(cfg_rdata[1]) && !$past(cfg_rdata[2]))); // R4
  AST_APERR_NEEDS_CHK: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rdata[8]) |-> $past(cfg_rdata[3])); // R5
  AST_DPERR_NEEDS_CHK: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rdata[9]) |-> $past(cfg_rdata[4])); // R6
  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> (cfg_rdata == 16'h0006)); // R10
endmodule

bind bus_resp_ctrl brc_checker u_brc_checker (
  .clk(clk), .rst(rst), .addr_valid(addr_valid), .cfg_rdata(cfg_rdata),
  .retry_out(retry_out), .terr_out(terr_out));

// File: tb/test_bus_resp_ctrl.sv
module test_bus_resp_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic av = 0, rd = 0, rg = 0, po = 0, mis = 0, pa = 0, pb = 0;
  logic peer = 0, ee = 0, wfree = 1, dv = 0;
  logic [31:0] baddr = '0, maddr = '0;
  logic [3:0]  bapar = '0;
  logic [63:0] bdata = '0, mdata = '0;
  logic [7:0]  bdpar = '0;
  logic retry_out, terr_out, irq_out;
  logic [3:0] addr_par_out;
  logic [7:0] data_par_out;

  int nchk = 0, nerr = 0;
  logic [15:0] c = 16'h0006;
  bit done = 0;

  always #5 clk = ~clk;

  bus_resp_ctrl i_bus_resp_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .addr_valid(av), .addr_is_read(rd), .addr_is_reg(rg), .addr_posted(po),
    .addr_misaligned(mis), .tgt_pci_a(pa), .tgt_pci_b(pb), .peer_reg_wr(peer),
    .eeprom_loading(ee), .wbuf_free(wfree), .bus_addr(baddr), .bus_addr_par(bapar),
    .data_valid(dv), .bus_data(bdata), .bus_data_par(bdpar), .mst_addr(maddr),
    .mst_data(mdata), .retry_out(retry_out), .terr_out(terr_out), .irq_out(irq_out),
    .addr_par_out(addr_par_out), .data_par_out(data_par_out));

  function automatic logic [7:0] lpar(logic [63:0] x, int n, logic even);
    logic [7:0] p = '0;
    for (int i = 0; i < n; i++) p[i] = (^x[i*8 +: 8]) ^ ~even;
    return p;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic good_par();
    logic [7:0] t;
    t = lpar({32'b0, baddr}, 4, c[5]); bapar = t[3:0];
    bdpar = lpar(bdata, 8, c[5]);
  endtask

  task automatic cyc();
    logic [15:0] nc;
    logic [7:0] ta, ea, ed;
    logic evm, eva, evd, er, et;
    ta  = lpar({32'b0, baddr}, 4, c[5]);
    evm = av & mis & ~c[2];
    eva = av & c[3] & (bapar != ta[3:0]);
    evd = dv & c[4] & (bdpar != lpar(bdata, 8, c[5]));
    er  = av & c[0] & ((rg & ~rd & peer) | (rg & rd & ee) | (po & ~wfree) | (rd & (pa | pb)));
    et  = c[1] & (evm | eva | evd);
    nc  = c;
    if (cfg_we) begin
      nc[5:0]  = cfg_wdata[5:0];
      nc[10:8] = nc[10:8] & ~cfg_wdata[10:8];
    end
    nc[8]  = nc[8] | eva;
    nc[9]  = nc[9] | evd;
    nc[10] = nc[10] | (evm & ~c[1]);
    ea = lpar({32'b0, maddr}, 4, c[5]);
    ed = lpar(mdata, 8, c[5]);
    @(posedge clk); #2;
    chk("R1 R2 retry", retry_out, er);
    chk("R3 R4 terr", terr_out, et);
    chk("R4 R5 R6 R9 R10 register", cfg_rdata, nc);
    chk("R9 irq", irq_out, |nc[10:8]);
    chk("R7 R8 address parity out", addr_par_out, ea[3:0]);
    chk("R7 R8 data parity out", data_par_out, ed);
    c = nc;
  endtask

  task automatic idle();
    cfg_we = 0; av = 0; dv = 0; rd = 0; rg = 0; po = 0; mis = 0;
    pa = 0; pb = 0; peer = 0; ee = 0; wfree = 1;
    good_par();
  endtask

  task automatic wr(logic [15:0] v);
    idle(); cfg_we = 1; cfg_wdata = v; cyc(); idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 0;
    chk("R10 reset value", cfg_rdata, 16'h0006);
    chk("R10 reset outputs", {retry_out, terr_out, irq_out}, 3'b000);
    // R8: generation with checks off
    idle(); maddr = 32'h8001_00ff; mdata = 64'h0123_4567_89ab_cdef; cyc();
    // R2: all retry causes, retry disabled
    idle(); av = 1; rd = 1; rg = 1; ee = 1; pa = 1; cyc();
    // R1: each retry cause alone
    wr(16'h0007);
    idle(); av = 1; rg = 1; peer = 1; cyc();
    idle(); av = 1; rg = 1; rd = 1; ee = 1; cyc();
    idle(); av = 1; po = 1; wfree = 0; cyc();
    idle(); av = 1; rd = 1; pb = 1; cyc();
    idle(); av = 1; rg = 1; peer = 1; rd = 1; cyc();
    idle(); cyc();
    // R4: reject with terr enabled, then routed to interrupt
    wr(16'h0003);
    idle(); av = 1; mis = 1; cyc();
    wr(16'h0001);
    idle(); av = 1; mis = 1; cyc();
    wr(16'h0401); // R9 clear flag
    // R5 R6 parity checks off then on
    idle(); av = 1; dv = 1; bapar = ~bapar; bdpar = bdpar ^ 8'h10; cyc();
    wr(16'h001a);
    idle(); av = 1; dv = 1; baddr = 32'hdead_beef; bdata = 64'hff; good_par();
    bapar[2] = ~bapar[2]; bdpar[7] = ~bdpar[7]; cyc();
    // R7 even polarity; R9 clear racing a new error
    wr(16'h033a);
    idle(); maddr = 32'h0000_0103; baddr = 32'h7; good_par(); av = 1; cyc();
    idle(); cfg_we = 1; cfg_wdata = 16'h0718; av = 1; bapar = ~bapar; cyc();
    wr(16'h0700);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      cfg_we = ($urandom % 12) == 0;
      cfg_wdata = $urandom;
      av = $urandom; dv = $urandom; rd = $urandom; rg = $urandom; po = $urandom;
      mis = $urandom; pa = ($urandom % 4) == 0; pb = ($urandom % 4) == 0;
      peer = $urandom; ee = $urandom; wfree = $urandom;
      baddr = $urandom; bdata = {$urandom, $urandom};
      maddr = $urandom; mdata = {$urandom, $urandom};
      good_par();
      if (($urandom % 6) == 0) bapar = bapar ^ 4'($urandom);
      if (($urandom % 6) == 0) bdpar = bdpar ^ 8'($urandom);
      cyc();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd20240611);
  end
endmodule